// File: doc/BRIEF.md
# Next Program Counter Unit for Branches and Jumps

This block decides where a 32-bit, byte-addressed, word-aligned instruction stream goes next. Each cycle it takes the address of the current instruction, its primary opcode and function code, the two source register values, the 16-bit offset field and the 26-bit jump field. It produces the next instruction address, a flag that says control flow left the sequential path, and a request to write a return address into link register 31.

Three kinds of redirect are supported. Conditional branches add a signed word distance to the sequential address. Region jumps keep the top bits of the current address and replace the rest with the jump field. Register jumps go to the address held in the first source register, and such a target that is not word aligned is flagged. All outputs are registered, so they appear one clock after the inputs are presented.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and as soon as it falls, `npc_o`, `taken_o`, `link_we_o`, `link_data_o` and `misalign_o` are all zero.
- R2: Any opcode other than 1 to 5, and opcode 0 with a function code other than 8, gives `npc_o` = `pc_i`+4 with `taken_o`, `link_we_o` and `misalign_o` low.
- R3: Opcode 4 (equal branch) is taken when `rs_val_i` equals `rt_val_i`: `npc_o` = `pc_i`+4 + (sign-extended `off_i` × 4) and `taken_o` high; otherwise `npc_o` = `pc_i`+4, `taken_o` low.
- R4: Opcode 5 (not-equal branch) computes the same target and is taken exactly when `rs_val_i` differs from `rt_val_i`.
- R5: Opcode 1 (branch on negative) is taken exactly when bit 31 of `rs_val_i` is set; zero and positive values fall through to `pc_i`+4.
- R6: The branch offset is two's complement: 0x8000 moves back 131072 bytes, 0x7FFF moves forward 131068 bytes, and the sum wraps modulo 2^32.
- R7: Opcode 2 (jump) gives `npc_o` = {`pc_i`[31:28], `jf_i`, 2'b00} with `taken_o` high; the upper bits come from the current address, not from `pc_i`+4.
- R8: Opcode 3 (jump and link) redirects as R7 and also raises `link_we_o` with `link_idx_o` = 31 and `link_data_o` = `pc_i`+4; for every other instruction `link_we_o` is low and `link_data_o` is zero.
- R9: Opcode 0 with function code 8 (register jump) gives `npc_o` = `rs_val_i` with `taken_o` high.
- R10: `misalign_o` is high exactly for a register jump whose target has a non-zero value in bits 1:0; the jump is still taken to that address.
- R11: Outputs change only at a rising clock edge and reflect the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| opcode_i | input | 6 | Primary opcode |
| funct_i | input | 6 | Function code, used with opcode 0 |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| off_i | input | 16 | Signed branch distance in words |
| jf_i | input | 26 | Jump word address field |
| npc_o | output | 32 | Next instruction address |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_we_o | output | 1 | Write request for the link register |
| link_idx_o | output | 5 | Index of the link register (31) |
| link_data_o | output | 32 | Return address to be written |
| misalign_o | output | 1 | Register jump target not word aligned |

## Verification
The redirect and the link write happen in the same cycle for a jump-and-link, and they use different addresses: the target keeps the top nibble of the current address while the return value is the incremented one. The bench places a jump-and-link at the last word of a 256 MB region, so the two disagree in their top bits, and judges both against hand-computed values. A register jump to an odd address likewise raises the redirect and the alignment flag together, and both are checked in that one cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam logic [5:0] OP_SPECIAL = 6'd0;
    localparam logic [5:0] OP_BNEG    = 6'd1;
    localparam logic [5:0] OP_JUMP    = 6'd2;
    localparam logic [5:0] OP_JLINK   = 6'd3;
    localparam logic [5:0] OP_BEQUAL  = 6'd4;
    localparam logic [5:0] OP_BDIFF   = 6'd5;
    localparam logic [5:0] FN_REGJMP  = 6'd8;

    typedef enum logic [2:0] {
        K_SEQ,
        K_BEQ,
        K_BNE,
        K_BNEG,
        K_JMP,
        K_JAL,
        K_JREG
    } flow_kind_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [5:0]  opcode_i,
    input  logic [5:0]  funct_i,
    output flow_kind_e  kind_o
);

    always_comb begin
        kind_o = K_SEQ;
        unique case (opcode_i)
            OP_SPECIAL: kind_o = (funct_i == FN_REGJMP) ? K_JREG : K_SEQ;
            OP_BNEG:    kind_o = K_BNEG;
            OP_JUMP:    kind_o = K_JMP;
            OP_JLINK:   kind_o = K_JAL;
            OP_BEQUAL:  kind_o = K_BEQ;
            OP_BDIFF:   kind_o = K_BNE;
            default:    kind_o = K_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  flow_kind_e          kind_i,
    input  logic [DATA_W-1:0]   rs_i,
    input  logic [DATA_W-1:0]   rt_i,
    output logic                redirect_o
);

    logic same;
    logic negative;

    assign same     = (rs_i == rt_i);
    assign negative = rs_i[DATA_W-1];

    always_comb begin
        unique case (kind_i)
            K_BEQ:                  redirect_o = same;
            K_BNE:                  redirect_o = !same;
            K_BNEG:                 redirect_o = negative;
            K_JMP, K_JAL, K_JREG:   redirect_o = 1'b1;
            default:                redirect_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int JF_W   = 26
) (
    input  flow_kind_e          kind_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [ADDR_W-1:0]   rs_i,
    input  logic [OFF_W-1:0]    off_i,
    input  logic [JF_W-1:0]     jf_i,
    output logic [ADDR_W-1:0]   seq_o,
    output logic [ADDR_W-1:0]   target_o
);

    localparam int EXT_W    = ADDR_W - OFF_W - 2;
    localparam int REGION_W = ADDR_W - JF_W - 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] br_disp;
    logic [ADDR_W-1:0] br_tgt;
    logic [ADDR_W-1:0] region_tgt;

    assign seq_o   = pc_i + STEP;
    assign br_disp = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
    assign br_tgt  = seq_o + br_disp;

    generate
        if (REGION_W > 0) begin : g_region
            assign region_tgt = {pc_i[ADDR_W-1 -: REGION_W], jf_i, 2'b00};
        end else begin : g_flat
            assign region_tgt = {jf_i, 2'b00};
        end
    endgenerate

    always_comb begin
        unique case (kind_i)
            K_BEQ, K_BNE, K_BNEG: target_o = br_tgt;
            K_JMP, K_JAL:         target_o = region_tgt;
            K_JREG:               target_o = rs_i;
            default:              target_o = seq_o;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int JF_W       = 26,
    parameter int LINK_IDX_W = 5,
    parameter int LINK_REG   = 31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       pc_i,
    input  logic [5:0]              opcode_i,
    input  logic [5:0]              funct_i,
    input  logic [ADDR_W-1:0]       rs_val_i,
    input  logic [ADDR_W-1:0]       rt_val_i,
    input  logic [OFF_W-1:0]        off_i,
    input  logic [JF_W-1:0]         jf_i,
    output logic [ADDR_W-1:0]       npc_o,
    output logic                    taken_o,
    output logic                    link_we_o,
    output logic [LINK_IDX_W-1:0]   link_idx_o,
    output logic [ADDR_W-1:0]       link_data_o,
    output logic                    misalign_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] npc;
        logic              taken;
        logic              link_we;
        logic [ADDR_W-1:0] link_data;
        logic              misalign;
    } npc_state_t;

    flow_kind_e         kind;
    logic               redirect;
    logic [ADDR_W-1:0]  seq_pc;
    logic [ADDR_W-1:0]  tgt_pc;
    npc_state_t         state_d;
    npc_state_t         state_q;

    npc_decode i_decode (
        .opcode_i (opcode_i),
        .funct_i  (funct_i),
        .kind_o   (kind)
    );

    npc_cond #(.DATA_W(ADDR_W)) i_cond (
        .kind_i     (kind),
        .rs_i       (rs_val_i),
        .rt_i       (rt_val_i),
        .redirect_o (redirect)
    );

    npc_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .JF_W(JF_W)) i_target (
        .kind_i   (kind),
        .pc_i     (pc_i),
        .rs_i     (rs_val_i),
        .off_i    (off_i),
        .jf_i     (jf_i),
        .seq_o    (seq_pc),
        .target_o (tgt_pc)
    );

    always_comb begin
        state_d           = '0;
        state_d.taken     = redirect;
        state_d.npc       = redirect ? tgt_pc : seq_pc;
        state_d.link_we   = (kind == K_JAL);
        state_d.link_data = (kind == K_JAL) ? seq_pc : '0;
        state_d.misalign  = (kind == K_JREG) && (rs_val_i[1:0] != 2'b00);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign npc_o       = state_q.npc;
    assign taken_o     = state_q.taken;
    assign link_we_o   = state_q.link_we;
    assign link_idx_o  = LINK_IDX_W'(LINK_REG);
    assign link_data_o = state_q.link_data;
    assign misalign_o  = state_q.misalign;

    // Outputs are quiet one edge into reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (npc_o == '0 && !taken_o && !link_we_o && !misalign_o));

    // Fall-through always lands on the word after the previous address.
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken_o) |-> (npc_o == $past(pc_i) + ADDR_W'(4)));

    // A negative source always redirects a negative-branch.
    p_bneg_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode_i == OP_BNEG) && $past(rs_val_i[ADDR_W-1]))
        |-> taken_o);

    // The return address is the word after the linking instruction.
    p_link_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (taken_o && link_data_o == $past(pc_i) + ADDR_W'(4)));

    // A register jump lands on the register value.
    p_regjump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode_i == OP_SPECIAL && funct_i == FN_REGJMP))
        |-> (taken_o && npc_o == $past(rs_val_i)));

    // The alignment flag only accompanies a redirect to an unaligned address.
    p_misalign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (taken_o && npc_o[1:0] != 2'b00 && !link_we_o));

endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    logic        clk;
    logic        rst_n;
    logic [31:0] pc_i;
    logic [5:0]  opcode_i;
    logic [5:0]  funct_i;
    logic [31:0] rs_val_i;
    logic [31:0] rt_val_i;
    logic [15:0] off_i;
    logic [25:0] jf_i;
    logic [31:0] npc_o;
    logic        taken_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_data_o;
    logic        misalign_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    npc_unit i_npc_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .pc_i        (pc_i),
        .opcode_i    (opcode_i),
        .funct_i     (funct_i),
        .rs_val_i    (rs_val_i),
        .rt_val_i    (rt_val_i),
        .off_i       (off_i),
        .jf_i        (jf_i),
        .npc_o       (npc_o),
        .taken_o     (taken_o),
        .link_we_o   (link_we_o),
        .link_idx_o  (link_idx_o),
        .link_data_o (link_data_o),
        .misalign_o  (misalign_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Stimulus: pc, opcode, funct, rs, rt, offset, jump field
    localparam logic [31:0] V_PC [NV] = '{
        32'h0040_0000, 32'h0040_0010, 32'h0040_0010, 32'h0040_0010, 32'h0040_0010,
        32'h0040_0100, 32'h0040_0100, 32'h0040_0100, 32'h0040_0000, 32'h0040_0000,
        32'h0000_0000, 32'h4000_1000, 32'hF000_0000, 32'h0FFF_FFFC, 32'h0040_0000,
        32'h0040_0000, 32'h0000_0100, 32'h0000_0200};
    localparam logic [5:0] V_OP [NV] = '{
        6'd0, 6'd4, 6'd4, 6'd5, 6'd5, 6'd1, 6'd1, 6'd1, 6'd4, 6'd4,
        6'd5, 6'd2, 6'd2, 6'd3, 6'd0, 6'd0, 6'd0, 6'd6};
    localparam logic [5:0] V_FN [NV] = '{
        6'd32, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0,
        6'd0, 6'd0, 6'd0, 6'd0, 6'd8, 6'd8, 6'd9, 6'd8};
    localparam logic [31:0] V_RS [NV] = '{
        32'h1, 32'h5, 32'h5, 32'h5, 32'h7, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0,
        32'h1, 32'h1, 32'h1, 32'h0, 32'h0, 32'h0, 32'h0040_0040, 32'h0040_0042,
        32'h1234, 32'h0040_0040};
    localparam logic [31:0] V_RT [NV] = '{
        32'h2, 32'h5, 32'h6, 32'h6, 32'h7, 32'h0, 32'h0, 32'h0,
        32'h1, 32'h1, 32'h2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic [15:0] V_OFF [NV] = '{
        16'h0, 16'h0003, 16'h0003, 16'hFFFE, 16'hFFFE, 16'h0010, 16'h0010, 16'h0010,
        16'h8000, 16'h7FFF, 16'hFFFE, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
    localparam logic [25:0] V_JF [NV] = '{
        26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0, 26'h0,
        26'h0, 26'h000_0100, 26'h3FF_FFFF, 26'h000_0010, 26'h0, 26'h0, 26'h0, 26'h0};

    // Expected: next address, taken, link write, link data, misaligned
    localparam logic [31:0] E_NPC [NV] = '{
        32'h0040_0004, 32'h0040_0020, 32'h0040_0014, 32'h0040_000C, 32'h0040_0014,
        32'h0040_0144, 32'h0040_0104, 32'h0040_0104, 32'h003E_0004, 32'h0042_0000,
        32'hFFFF_FFFC, 32'h4000_0400, 32'hFFFF_FFFC, 32'h0000_0040, 32'h0040_0040,
        32'h0040_0042, 32'h0000_0104, 32'h0000_0204};
    localparam logic E_TK [NV] = '{
        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
        1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic E_LK [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [31:0] E_LD [NV] = '{
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h1000_0000, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic E_MA [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    // Requirement tag per vector
    localparam string V_REQ [NV] = '{
        "R2", "R3", "R3", "R4", "R4", "R5", "R5", "R5", "R6", "R6",
        "R6", "R7", "R7", "R8", "R9", "R10", "R2", "R2"};

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] pc, input logic [5:0] op, input logic [5:0] fn,
                         input logic [31:0] rs, input logic [31:0] rt,
                         input logic [15:0] off, input logic [25:0] jf);
        pc_i = pc; opcode_i = op; funct_i = fn;
        rs_val_i = rs; rt_val_i = rt; off_i = off; jf_i = jf;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst_n = 1'b0;
        drive(32'h0000_1000, 6'd3, 6'd0, 32'h0, 32'h0, 16'h0, 26'h1);
        repeat (3) @(negedge clk);
        // R1: reset holds every output at zero, even with a jump-and-link applied
        check("R1", "npc", npc_o, 32'h0);
        check("R1", "taken", {31'h0, taken_o}, 32'h0);
        check("R1", "link_we", {31'h0, link_we_o}, 32'h0);
        check("R1", "link_data", link_data_o, 32'h0);
        check("R1", "misalign", {31'h0, misalign_o}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(V_PC[i], V_OP[i], V_FN[i], V_RS[i], V_RT[i], V_OFF[i], V_JF[i]);
            @(negedge clk);
            check(V_REQ[i], "npc", npc_o, E_NPC[i]);
            check(V_REQ[i], "taken", {31'h0, taken_o}, {31'h0, E_TK[i]});
            check(V_REQ[i], "link_we", {31'h0, link_we_o}, {31'h0, E_LK[i]});
            check(V_REQ[i], "link_data", link_data_o, E_LD[i]);
            check(V_REQ[i], "misalign", {31'h0, misalign_o}, {31'h0, E_MA[i]});
            if (E_LK[i]) check("R8", "link_idx", {27'h0, link_idx_o}, 32'd31);
        end

        // R11: a new input is invisible until the next rising edge
        drive(32'h0000_0300, 6'd0, 6'd8, 32'h00AB_C000, 32'h0, 16'h0, 26'h0);
        #(CLK_PERIOD/4);
        check("R11", "npc before edge", npc_o, 32'h0000_0204);
        check("R11", "taken before edge", {31'h0, taken_o}, 32'h0);
        @(negedge clk);
        check("R11", "npc after edge", npc_o, 32'h00AB_C000);
        check("R11", "taken after edge", {31'h0, taken_o}, 32'h1);

        // R8 then R1: link request cleared at once by a reset
        drive(32'h0000_0100, 6'd3, 6'd0, 32'h0, 32'h0, 16'h0, 26'h1);
        @(negedge clk);
        check("R8", "link_we", {31'h0, link_we_o}, 32'h1);
        check("R8", "npc", npc_o, 32'h0000_0004);
        rst_n = 1'b0;
        #1;
        check("R1", "link_we on reset", {31'h0, link_we_o}, 32'h0);
        check("R1", "npc on reset", npc_o, 32'h0);
        @(negedge clk);
        report();
    end

endmodule